// File: doc/BRIEF.md
# Second-Order Mismatch-Shaping Element Encoder

This block produces the drive pattern for a binary-weighted bank of unit current or charge elements, so that the bank's total output follows the second difference of an input code. Element mismatch is then pushed to high frequencies with a (1 − z⁻¹)² shape. Each bit of the code has its own group of four elements: two positive and two negative. Bit k's group carries weight 2^k. No thermometer decoding and no scrambler are used.

Each bit position passes through a three-stage tap chain. The two negative elements always carry the middle tap. The two positive elements carry the newest and the oldest tap, and swap these roles every clock under a single toggling phase flop. Over two cycles, each positive element therefore carries the newest tap once and the oldest tap once. A signed output rebuilds the weighted sum of all elements, which lets the surrounding logic or a checker see the value the bank delivers.

The code is a continuous stream: one new code is taken on every clock, and there is no valid/ready handshake and no back-pressure, because the element bank must be updated every cycle. Reset is synchronous and active high.

Top module: `d2_elem_encoder`

## Requirements
- R1: While reset is high at a clock edge, all element enables, `swap_phase` and `dsum` are zero after that edge, whatever the value of `code`.
- R2: `swap_phase` is 1 after the first edge after reset release and inverts on every later edge.
- R3: For every bit k, `neg_a[k]` and `neg_b[k]` both equal bit k of the middle tap. The middle tap is the code sampled one edge before the newest tap.
- R4: When `swap_phase` is 0, `pos_a` carries the newest tap and `pos_b` carries the oldest tap. When `swap_phase` is 1 the two roles are exchanged. The oldest tap is the code sampled two edges before the newest tap.
- R5: In each cycle, the negative elements equal the value that the positive element holding the newest tap carried in the previous cycle (second differentiator stage).
- R6: `dsum` equals pos_a + pos_b − neg_a − neg_b, with each vector read as an unsigned binary number, so bit k weighs 2^k.
- R7: A code driven before clock edge E appears as the newest tap in the outputs after edge E+1. In that cycle, `dsum` = newest − 2·middle + oldest.
- R8: Code bit k affects only element group k. The element vectors are the tap codes routed bit for bit, with no decoding.
- R9: Full-scale alternation between 0 and 2^B−1 drives `dsum` to exactly +2(2^B−1) and −2(2^B−1) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code | input | B | Binary input code, one per clock |
| pos_a | output | B | Positive element A enable, one bit per weight |
| pos_b | output | B | Positive element B enable, one bit per weight |
| neg_a | output | B | Negative element A enable, one bit per weight |
| neg_b | output | B | Negative element B enable, one bit per weight |
| swap_phase | output | 1 | Current positive-element role phase |
| dsum | output | B+2 | Signed weighted sum of all element enables |

## Verification
The bench builds the block with the default B = 4, so the code space has only sixteen values. This makes the full-scale extremes of ±30 and a walk of a single set bit through every weight easy to reach. A long pseudo-random stream then covers many newest/middle/oldest triples under both swap phases. A second reset in the middle of the run shows that the tap chain and the phase restart cleanly while the input is held at full scale.

// File: rtl/d2enc_pkg.sv
package d2enc_pkg;

  // Drive state of one weight's four-element group
  typedef struct packed {
    logic pa;   // positive element A
    logic pb;   // positive element B
    logic na;   // negative element A
    logic nb;   // negative element B
  } elem_grp_t;

  // Route three taps onto a group for the given swap phase
  function automatic elem_grp_t route_group(input logic newest,
                                            input logic mid,
                                            input logic oldest,
                                            input logic phase);
    elem_grp_t g;
    g.pa = phase ? oldest : newest;
    g.pb = phase ? newest : oldest;
    g.na = mid;
    g.nb = mid;
    return g;
  endfunction

endpackage

// File: rtl/d2enc_phase.sv
module d2enc_phase (
  input  logic clk,
  input  logic rst,
  output logic ph,
  output logic ph_nxt
);

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ph_nxt;
  end

  assign ph_nxt = ~ph;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ph != $past(ph)));

  // R1
  phase_reset_chk: assert property (@(posedge clk)
    rst |=> (ph == 1'b0));

endmodule

// File: rtl/d2enc_slice.sv
module d2enc_slice
  import d2enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  logic      ph,
  input  logic      ph_nxt,
  output elem_grp_t grp
);

  logic tap_new, tap_mid, tap_old;
  elem_grp_t grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_new <= 1'b0;
      tap_mid <= 1'b0;
      tap_old <= 1'b0;
      grp_q   <= '0;
    end else begin
      tap_new <= din;
      tap_mid <= tap_new;
      tap_old <= tap_mid;
      grp_q   <= route_group(tap_new, tap_mid, tap_old, ph_nxt);
    end
  end

  assign grp = grp_q;

  // R5
  pair_diff_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (grp_q.na == ($past(ph) ? $past(grp_q.pb) : $past(grp_q.pa))));

  // R4
  oldest_role_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ph ? grp_q.pa : grp_q.pb) == $past(grp_q.na)));

endmodule

// File: rtl/d2enc_sum.sv
module d2enc_sum #(
  parameter int B = 4
) (
  input  logic [B-1:0]        pa,
  input  logic [B-1:0]        pb,
  input  logic [B-1:0]        na,
  input  logic [B-1:0]        nb,
  output logic signed [B+1:0] dsum
);

  localparam int SW = B + 2;

  logic [SW-1:0] pos_tot, neg_tot;

  assign pos_tot = SW'(pa) + SW'(pb);
  assign neg_tot = SW'(na) + SW'(nb);
  assign dsum    = $signed(pos_tot - neg_tot);

endmodule

// File: rtl/d2_elem_encoder.sv
module d2_elem_encoder
  import d2enc_pkg::*;
#(
  parameter int B = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [B-1:0]        code,
  output logic [B-1:0]        pos_a,
  output logic [B-1:0]        pos_b,
  output logic [B-1:0]        neg_a,
  output logic [B-1:0]        neg_b,
  output logic                swap_phase,
  output logic signed [B+1:0] dsum
);

  localparam int WARM = 4;
  localparam int WW   = $clog2(WARM + 1);

  logic      ph, ph_nxt;
  elem_grp_t grp [B];

  d2enc_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .ph     (ph),
    .ph_nxt (ph_nxt)
  );

  for (genvar k = 0; k < B; k++) begin : g_bit
    d2enc_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .din    (code[k]),
      .ph     (ph),
      .ph_nxt (ph_nxt),
      .grp    (grp[k])
    );
    assign pos_a[k] = grp[k].pa;
    assign pos_b[k] = grp[k].pb;
    assign neg_a[k] = grp[k].na;
    assign neg_b[k] = grp[k].nb;
  end

  d2enc_sum #(.B(B)) u_sum (
    .pa   (pos_a),
    .pb   (pos_b),
    .na   (neg_a),
    .nb   (neg_b),
    .dsum (dsum)
  );

  assign swap_phase = ph;

  // Cycles since reset release, saturating; gates the history-based check
  logic [WW-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)                   warm <= '0;
    else if (warm != WW'(WARM)) warm <= warm + 1'b1;
  end

  // R7
  second_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == WW'(WARM)) |->
      (int'(dsum) == int'($past(code, 2)) - 2 * int'($past(code, 3)) + int'($past(code, 4))));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dsum == '0 && pos_a == '0 && pos_b == '0 && neg_a == '0 && neg_b == '0));

endmodule

// File: tb/test_d2_elem_encoder.sv
`timescale 1ns/1ps
module test_d2_elem_encoder;

  localparam int B    = 4;
  localparam int MAXV = (1 << B) - 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [B-1:0]        code = '0;
  logic [B-1:0]        pos_a, pos_b, neg_a, neg_b;
  logic                swap_phase;
  logic signed [B+1:0] dsum;

  always #10 clk = ~clk;

  d2_elem_encoder #(.B(B)) i_d2_elem_encoder (
    .clk        (clk),
    .rst        (rst),
    .code       (code),
    .pos_a      (pos_a),
    .pos_b      (pos_b),
    .neg_a      (neg_a),
    .neg_b      (neg_b),
    .swap_phase (swap_phase),
    .dsum       (dsum)
  );

  typedef struct {
    int pa; int pb; int na; int nb; int ph; int sum;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  int m_cnt = 0, h1 = 0, h2 = 0;
  bit have_prev = 0;
  int prev_pa = 0, prev_pb = 0, prev_ph = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: one pushed item per code taken by the block
  task automatic push_model(input int v);
    exp_t e;
    m_cnt++;
    e.ph = (m_cnt + 1) % 2;
    if (e.ph == 0) begin e.pa = v;  e.pb = h2; end
    else           begin e.pa = h2; e.pb = v;  end
    e.na  = h1;
    e.nb  = h1;
    e.sum = v - 2 * h1 + h2;
    q.push_back(e);
    h2 = h1;
    h1 = v;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    code = B'(v);
    push_model(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst  = 1'b1;
    code = '1;          // full-scale input held during reset must be ignored
    q.delete();
    have_prev = 0;
    repeat (3) @(posedge clk);
    #5;
    check_eq("R1 pos_a", int'(pos_a), 0);
    check_eq("R1 pos_b", int'(pos_b), 0);
    check_eq("R1 neg_a", int'(neg_a), 0);
    check_eq("R1 neg_b", int'(neg_b), 0);
    check_eq("R1 swap_phase", int'(swap_phase), 0);
    check_eq("R1 dsum", int'(dsum), 0);
    @(negedge clk);
    rst  = 1'b0;
    code = '0;
    m_cnt = 0; h1 = 0; h2 = 0;
    push_model(0);
  endtask

  // Monitor: pops the item due after each edge and compares
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (!rst && q.size() >= 2) begin
        e = q.pop_front();
        if (e.sum == 2 * MAXV || e.sum == -2 * MAXV)
          check_eq("R9 full-scale dsum", int'(dsum), e.sum);
        else
          check_eq("R7 dsum second difference", int'(dsum), e.sum);
        check_eq("R6 element sum", int'(dsum),
                 int'(pos_a) + int'(pos_b) - int'(neg_a) - int'(neg_b));
        check_eq("R4 R8 pos_a", int'(pos_a), e.pa);
        check_eq("R4 R8 pos_b", int'(pos_b), e.pb);
        check_eq("R3 R8 neg_a", int'(neg_a), e.na);
        check_eq("R3 R8 neg_b", int'(neg_b), e.nb);
        check_eq("R2 swap_phase", int'(swap_phase), e.ph);
        if (have_prev) begin
          check_eq("R2 phase toggle", int'(swap_phase), 1 - prev_ph);
          check_eq("R5 pair differentiator", int'(neg_a),
                   (prev_ph == 0) ? prev_pa : prev_pb);
        end
        have_prev = 1;
        prev_pa = int'(pos_a);
        prev_pb = int'(pos_b);
        prev_ph = int'(swap_phase);
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    do_reset();
    repeat (6) send(0);
    repeat (6) send(MAXV);
    for (int i = 0; i < 10; i++) send((i % 2 == 1) ? MAXV : 0);
    for (int v = 0; v <= MAXV; v++) send(v);
    for (int b = 0; b < B; b++) begin
      send(1 << b);
      send(0);
      send(0);
    end
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'(lfsr[B-1:0]));
    end
    repeat (3) send(0);
    @(posedge clk);
    #8;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule